// File: doc/BRIEF.md
# Interrupt Context Save Sequencer

When an interrupt is accepted, this block stores the 20-bit program counter and the 16-bit flag word on a byte-addressed stack that grows downwards. It decides which stack pointer is in use and looks at bit 0 of that pointer. If the pointer is even, the block stores the context as two halfword writes. If it is odd, it stores the context as four byte writes. The memory image is the same in both cases. The top nibble of the flags and the top nibble of the program counter share one byte.

All inputs are captured in the cycle that the accept strobe is taken. Each write is presented on the bus and held until the bus returns ready. After the last write, the block gives a one-cycle done pulse. In that same cycle it offers the new pointer value (the old value minus four) to the pointer register it chose. The surrounding core stores that value.

Top module: `irq_ctx_saver`

## Requirements
- R1: The user pointer `usp_i` is used only when both `soft_hi_i` (software interrupt numbered 32 to 63) and `ustk_flag_i` are 1 at accept. In every other case the interrupt pointer `isp_i` is used.
- R2: For an even selected pointer S, there are exactly two writes with `bus_wide_o`=1. The first goes to address S-2 with data {mixed byte, flags[7:0]}. The second goes to S-4 with data pc[15:0]. The low data byte belongs to the lower address.
- R3: For an odd selected pointer S, there are exactly four writes with `bus_wide_o`=0. They go to S-1, S-2, S-3 and S-4, in that order. The data in bits 7:0 is the mixed byte, then flags[7:0], then pc[15:8], then pc[7:0]. Data bits 15:8 are 0.
- R4: The mixed byte is {flags[15:12], pc[19:16]}.
- R5: A write keeps its address, data and width unchanged while `bus_rdy_i` is 0. The write completes on a clock edge where `bus_we_o` and `bus_rdy_i` are both 1. The next write appears in the cycle after that edge.
- R6: An accept strobe is ignored from the accept cycle until the cycle after the done pulse.
- R7: `done_o` is high for exactly one cycle: the cycle after the last write completes.
- R8: During the done cycle, `sp_wb_o` equals S-4 modulo 2^16. Exactly one of `isp_wb_o` and `usp_wb_o` is 1, namely the one for the pointer that was selected. Outside the done cycle, both are 0.
- R9: After reset, `bus_we_o`, `done_o`, `isp_wb_o` and `usp_wb_o` are 0.
- R10: Changes to the pc, flag and pointer inputs after the accept cycle do not affect the save in progress.
- R11: Pointer arithmetic wraps modulo 2^16. The bus address is the 16-bit result, zero-extended to 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted; starts a save when idle |
| pc_i | input | 20 | Program counter to save |
| flags_i | input | 16 | Flag word to save |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| soft_hi_i | input | 1 | Request is a software interrupt numbered 32 to 63 |
| ustk_flag_i | input | 1 | Stack select flag from the flag word |
| bus_rdy_i | input | 1 | Bus accepts the current write |
| bus_addr_o | output | 20 | Write address |
| bus_data_o | output | 16 | Write data |
| bus_wide_o | output | 1 | 1 = halfword write, 0 = byte write in bits 7:0 |
| bus_we_o | output | 1 | Write request |
| done_o | output | 1 | One-cycle completion pulse |
| sp_wb_o | output | 16 | New pointer value |
| isp_wb_o | output | 1 | Store `sp_wb_o` into the interrupt pointer |
| usp_wb_o | output | 1 | Store `sp_wb_o` into the user pointer |

## Verification
The first write appears one cycle after the edge that samples the accept strobe. Each later write appears one cycle after the edge on which the previous write saw ready. The done pulse and the pointer write-back come one cycle after the last ready edge. The bench drives its inputs and samples the outputs on the falling edge. It checks the pending write against a bench-computed list in every waiting cycle, so the hold rule is checked in each cycle that ready is low. It moves to the next list entry only after a falling edge at which it set ready. After the last entry it expects done at the next falling edge and expects it to be gone one falling edge later.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;
  localparam int PC_W    = 20;
  localparam int FLG_W   = 16;
  localparam int BUS_W   = 16;
  localparam int FRAME_W = 32;
  localparam int STEP_W  = 2;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_PUSH = 2'd1,
    CS_DONE = 2'd2
  } cs_state_e;

  // shared byte: flag top nibble above pc top nibble
  function automatic logic [7:0] ctx_mixed_byte(input logic [PC_W-1:0] pc,
                                                input logic [FLG_W-1:0] flg);
    return {flg[FLG_W-1 -: 4], pc[PC_W-1 -: 4]};
  endfunction

  // frame byte i sits at stack offset -(4-i)
  function automatic logic [FRAME_W-1:0] ctx_frame(input logic [PC_W-1:0] pc,
                                                   input logic [FLG_W-1:0] flg);
    return {ctx_mixed_byte(pc, flg), flg[7:0], pc[15:0]};
  endfunction

  // distance below the initial pointer for a given step
  function automatic logic [2:0] ctx_depth(input logic odd,
                                           input logic [STEP_W-1:0] step);
    if (odd) return 3'(step) + 3'd1;
    return (step == '0) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [STEP_W-1:0] ctx_last_step(input logic odd);
    return odd ? STEP_W'(3) : STEP_W'(1);
  endfunction

  function automatic logic [BUS_W-1:0] ctx_lane(input logic [FRAME_W-1:0] frame,
                                                input logic odd,
                                                input logic [STEP_W-1:0] step);
    int idx;
    idx = 4 - int'(ctx_depth(odd, step));
    if (odd) return {8'h00, frame[idx*8 +: 8]};
    return frame[idx*8 +: 16];
  endfunction
endpackage

// File: rtl/irq_sp_select.sv
module irq_sp_select #(
  parameter int SP_W = 16
) (
  input  logic [SP_W-1:0] isp,
  input  logic [SP_W-1:0] usp,
  input  logic            soft_hi,
  input  logic            ustk_flag,
  output logic            use_usp,
  output logic [SP_W-1:0] sp_pick,
  output logic            pick_odd
);
  always_comb begin
    use_usp  = soft_hi & ustk_flag;
    sp_pick  = use_usp ? usp : isp;
    pick_odd = sp_pick[0];
  end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import ctx_save_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              odd,
  input  logic              bus_rdy,
  output logic              start,
  output logic              push_active,
  output logic [STEP_W-1:0] step,
  output logic              push_fire,
  output logic              last_fire,
  output logic              done
);
  cs_state_e state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    start       = (state_q == CS_IDLE) && accept;
    push_active = (state_q == CS_PUSH);
    push_fire   = push_active && bus_rdy;
    last_fire   = push_fire && (step_q == ctx_last_step(odd));
    done        = (state_q == CS_DONE);
    step        = step_q;
    state_d     = state_q;
    step_d      = step_q;
    unique case (state_q)
      CS_IDLE: if (start) begin state_d = CS_PUSH; step_d = '0; end
      CS_PUSH: begin
        if (last_fire)      state_d = CS_DONE;
        else if (push_fire) step_d  = step_q + STEP_W'(1);
      end
      CS_DONE: state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> done);
  a_r6_accept_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && push_active && !push_fire) |=> (push_active && $stable(step)));
  a_r6_no_restart_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !push_active);
endmodule

// File: rtl/irq_ctx_bus.sv
module irq_ctx_bus
  import ctx_save_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int ADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               bus_rdy,
  input  logic               odd,
  input  logic [STEP_W-1:0]  step,
  input  logic [SP_W-1:0]    sp_base,
  input  logic [FRAME_W-1:0] frame,
  output logic [ADDR_W-1:0]  addr,
  output logic [BUS_W-1:0]   data,
  output logic               wide,
  output logic               we
);
  logic [SP_W-1:0] sp_off;

  always_comb begin
    sp_off = sp_base - SP_W'(ctx_depth(odd, step));
    addr   = active ? ADDR_W'(sp_off) : '0;
    data   = active ? ctx_lane(frame, odd, step) : '0;
    wide   = active && !odd;
    we     = active;
  end

  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !bus_rdy) |=> (we && $stable(addr) && $stable(data) && $stable(wide)));
  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wide) |-> (data[15:8] == 8'h00));
  a_r2_even_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wide) |-> (addr[0] == 1'b0));
endmodule

// File: rtl/irq_ctx_saver.sv
module irq_ctx_saver
  import ctx_save_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FLG_W-1:0]  flags_i,
  input  logic [SP_W-1:0]   isp_i,
  input  logic [SP_W-1:0]   usp_i,
  input  logic              soft_hi_i,
  input  logic              ustk_flag_i,
  input  logic              bus_rdy_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BUS_W-1:0]  bus_data_o,
  output logic              bus_wide_o,
  output logic              bus_we_o,
  output logic              done_o,
  output logic [SP_W-1:0]   sp_wb_o,
  output logic              isp_wb_o,
  output logic              usp_wb_o
);
  localparam int FRAME_BYTES = FRAME_W / 8;

  function automatic logic [SP_W-1:0] sp_after(input logic [SP_W-1:0] sp);
    return sp - SP_W'(FRAME_BYTES);
  endfunction

  logic              use_usp, pick_odd;
  logic [SP_W-1:0]   sp_pick;
  logic              start, push_active, push_fire, last_fire, done;
  logic [STEP_W-1:0] step;
  logic [FRAME_W-1:0] frame_q;
  logic [SP_W-1:0]   sp_q;
  logic              odd_q, usp_q;

  irq_sp_select #(.SP_W(SP_W)) u_sel (
    .isp(isp_i), .usp(usp_i), .soft_hi(soft_hi_i), .ustk_flag(ustk_flag_i),
    .use_usp(use_usp), .sp_pick(sp_pick), .pick_odd(pick_odd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      sp_q    <= '0;
      odd_q   <= 1'b0;
      usp_q   <= 1'b0;
    end else if (start) begin
      frame_q <= ctx_frame(pc_i, flags_i);
      sp_q    <= sp_pick;
      odd_q   <= pick_odd;
      usp_q   <= use_usp;
    end
  end

  irq_ctx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept_i), .odd(odd_q), .bus_rdy(bus_rdy_i),
    .start(start), .push_active(push_active), .step(step),
    .push_fire(push_fire), .last_fire(last_fire), .done(done)
  );

  irq_ctx_bus #(.SP_W(SP_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .active(push_active), .bus_rdy(bus_rdy_i),
    .odd(odd_q), .step(step), .sp_base(sp_q), .frame(frame_q),
    .addr(bus_addr_o), .data(bus_data_o), .wide(bus_wide_o), .we(bus_we_o)
  );

  always_comb begin
    done_o   = done;
    sp_wb_o  = sp_after(sp_q);
    isp_wb_o = done && !usp_q;
    usp_wb_o = done && usp_q;
  end

  a_r1_user_pick: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (usp_q == $past(soft_hi_i && ustk_flag_i)));
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({isp_wb_o, usp_wb_o}));
  a_r8_target_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (isp_wb_o || usp_wb_o));
  a_r10_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (push_active && !last_fire) |=> $stable(frame_q) && $stable(sp_q));
  a_r3_odd_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_o && odd_q) |-> !bus_wide_o);
  a_r7_push_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !last_fire) |=> push_active);
endmodule

// File: tb/irq_ctx_saver_tb.sv
module irq_ctx_saver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept_i = 1'b0;
  logic [19:0] pc_i = '0;
  logic [15:0] flags_i = '0;
  logic [15:0] isp_i = '0, usp_i = '0;
  logic        soft_hi_i = 1'b0, ustk_flag_i = 1'b0, bus_rdy_i = 1'b0;
  logic [19:0] bus_addr_o;
  logic [15:0] bus_data_o;
  logic        bus_wide_o, bus_we_o, done_o, isp_wb_o, usp_wb_o;
  logic [15:0] sp_wb_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_ctx_saver u_dut (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .pc_i(pc_i), .flags_i(flags_i),
    .isp_i(isp_i), .usp_i(usp_i), .soft_hi_i(soft_hi_i), .ustk_flag_i(ustk_flag_i),
    .bus_rdy_i(bus_rdy_i), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .bus_wide_o(bus_wide_o), .bus_we_o(bus_we_o), .done_o(done_o), .sp_wb_o(sp_wb_o),
    .isp_wb_o(isp_wb_o), .usp_wb_o(usp_wb_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte stored at distance k below the initial pointer
  function automatic logic [7:0] byte_at(input logic [19:0] pc, input logic [15:0] f, input int k);
    case (k)
      1: return {f[15:12], pc[19:16]};
      2: return f[7:0];
      3: return pc[15:8];
      default: return pc[7:0];
    endcase
  endfunction

  function automatic int depth_of(input logic odd, input int i);
    return odd ? i + 1 : 2 + 2 * i;
  endfunction

  function automatic logic [15:0] data_of(input logic [19:0] pc, input logic [15:0] f,
                                          input logic odd, input int i);
    int k;
    k = depth_of(odd, i);
    if (odd) return {8'h00, byte_at(pc, f, k)};
    return {byte_at(pc, f, k - 1), byte_at(pc, f, k)};
  endfunction

  task automatic run_save(input logic [19:0] pc, input logic [15:0] f,
                          input logic [15:0] isp, input logic [15:0] usp,
                          input logic sh, input logic uf, input int rdy_mode,
                          input logic disturb);
    logic        user;
    logic [15:0] s;
    logic        odd;
    int          n, i, guard;
    logic [15:0] a16;
    user = sh && uf;
    s    = user ? usp : isp;
    odd  = s[0];
    n    = odd ? 4 : 2;
    @(negedge clk);
    pc_i = pc; flags_i = f; isp_i = isp; usp_i = usp;
    soft_hi_i = sh; ustk_flag_i = uf; accept_i = 1'b1; bus_rdy_i = 1'b0;
    @(negedge clk);
    accept_i = disturb;  // R6: strobe held high while busy
    if (disturb) begin   // R10: inputs changed after accept
      pc_i = 20'($urandom); flags_i = 16'($urandom);
      isp_i = 16'($urandom); usp_i = 16'($urandom);
      soft_hi_i = ~sh; ustk_flag_i = ~uf;
    end
    i = 0; guard = 0;
    while (i < n && guard < 200) begin
      a16 = s - 16'(depth_of(odd, i));
      check(odd ? "R3 we" : "R2 we", {63'd0, bus_we_o}, 64'd1);
      check(odd ? "R3 addr" : "R2 addr", {44'd0, bus_addr_o}, {48'd0, a16});  // R11
      check(odd ? "R3 data" : "R2 data R4", {48'd0, bus_data_o}, {48'd0, data_of(pc, f, odd, i)});
      check("R5 width", {63'd0, bus_wide_o}, {63'd0, !odd});
      check("R7 no early done", {63'd0, done_o}, 64'd0);
      case (rdy_mode)
        0: bus_rdy_i = 1'b1;
        1: bus_rdy_i = (guard % 3) == 2;
        default: bus_rdy_i = ($urandom % 3) != 0;
      endcase
      if (bus_rdy_i) i++;
      guard++;
      @(negedge clk);
    end
    if (guard >= 200) check("R5 progress", 64'd0, 64'd1);
    bus_rdy_i = 1'b0;
    check("R7 done", {63'd0, done_o}, 64'd1);
    check("R8 sp", {48'd0, sp_wb_o}, {48'd0, s - 16'd4});
    check("R8 R1 target", {62'd0, isp_wb_o, usp_wb_o}, {62'd0, !user, user});
    check("R5 no extra write", {63'd0, bus_we_o}, 64'd0);
    @(negedge clk);
    accept_i = 1'b0;
    check("R7 done pulse ends", {61'd0, done_o, isp_wb_o, usp_wb_o}, 64'd0);
    check("R6 no write after done", {63'd0, bus_we_o}, 64'd0);
    @(negedge clk);
    check("R6 accept in done ignored", {63'd0, bus_we_o}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R9 reset", {60'd0, bus_we_o, done_o, isp_wb_o, usp_wb_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", {60'd0, bus_we_o, done_o, isp_wb_o, usp_wb_o}, 64'd0);
    // directed corners
    run_save(20'hA1234, 16'hC0DE, 16'h0400, 16'h0800, 1'b0, 1'b0, 0, 1'b0); // R2
    run_save(20'h5F00D, 16'h7E81, 16'h0401, 16'h0800, 1'b0, 1'b1, 0, 1'b0); // R3 R1
    run_save(20'hFFFFF, 16'hFFFF, 16'h0400, 16'h0933, 1'b1, 1'b1, 1, 1'b0); // R1 user odd
    run_save(20'h12345, 16'h8001, 16'h1001, 16'h2000, 1'b1, 1'b1, 1, 1'b1); // R1 user even, R10
    run_save(20'h00000, 16'h0000, 16'h0402, 16'h0500, 1'b1, 1'b0, 2, 1'b1); // R1 isp
    run_save(20'h9ABCD, 16'h3C5A, 16'h0002, 16'h0001, 1'b0, 1'b0, 2, 1'b0); // R11 wrap even
    run_save(20'h6789A, 16'hA55A, 16'h0001, 16'h0003, 1'b0, 1'b0, 1, 1'b1); // R11 wrap odd
    for (int t = 0; t < 40; t++) begin
      run_save(20'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               1'($urandom), 1'($urandom), 2, 1'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule